// File: doc/BRIEF.md
# Two-Beat Burst SRAM with Separate Data Ports

A synthesizable behavioural model of a synchronous static RAM with one write data port and one read data port. Every command moves two words in a burst. Everything runs on a single fast clock at twice the word rate. The phase input is high on the half-cycle whose closing edge stands for the rising edge of the logical clock, and low on the half-cycle in between. Commands and addresses are taken only on edges where the phase is high. The second word of a burst belongs to the address with its least significant bit flipped, so a burst stays inside an aligned pair of words.

A write puts its first word into the array on the command edge and its second word on the edge that follows. Each beat carries its own pair of active-low lane strobes. A read returns its first word three fast-clock edges after the command edge and its second word one edge later, which is one and a half logical cycles. A read and a write can both be accepted in the same command slot. When both selects are high, the slot is a no-op. The valid flag is meant to act as the drive enable of an external tri-state buffer.

Top module: `sram_b2`

## Requirements
- R1: A command is accepted only on a clk_i rising edge where phase_i is 1. A read is requested when rps_ni is 0 and a write when wps_ni is 0. Select levels on edges where phase_i is 0 have no effect.
- R2: A write accepted with address A stores the wdata_i present on the command edge at A. It stores the wdata_i present on the next edge at A with bit 0 inverted, so address 7 pairs with 6 and 6 pairs with 7.
- R3: A read accepted at address A on edge e puts mem[A] on rdata_o, with rvld_o at 1, for the half-cycle after edge e+3. It puts mem[A with bit 0 inverted] there for the half-cycle after edge e+4.
- R4: rvld_o is 1 only on half-cycles that carry read data. While rvld_o is 0, rdata_o is all zeros.
- R5: When rps_ni and wps_ni are both 1 on a command edge, no array word changes and no read data follows, whatever wdata_i and bw_ni carry.
- R6: bw_ni[0] at 0 writes bits [8:0] and bw_ni[1] at 0 writes bits [17:9]. With both at 0 the full word is written. With both at 1 nothing is written. A lane that is not written keeps its old contents.
- R7: bw_ni is sampled separately on each of the two beats of a write, so the two words of one burst may use different lane masks.
- R8: A read returns data written by a write accepted in the same command slot or in an earlier one, including a read and a write to the same address accepted together.
- R9: While rst_ni is 0, and after it is released until a read is accepted, rvld_o is 0 and rdata_o is zero.
- R10: While clk_i is stopped, rdata_o, rvld_o and the array contents hold their previous values.
- R11: Reads accepted on consecutive command edges produce an unbroken stream of valid beats, with rvld_o held at 1 across the bursts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock at twice the word rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 1 | 1 on the edge that stands for the logical rising edge |
| rps_ni | input | 1 | Read select, active low |
| wps_ni | input | 1 | Write select, active low |
| addr_i | input | 8 | Burst start address |
| wdata_i | input | 18 | Write data, one word per edge |
| bw_ni | input | 2 | Lane write strobes for the current beat, active low |
| rdata_o | output | 18 | Read data, zero when not valid |
| rvld_o | output | 1 | Read data valid / drive enable |

## Verification
The array is first filled with address-dependent patterns. Single reads then expose the latency and the pairing of the two beats. Reads issued back to back show whether rvld_o stays high across burst boundaries. All sixteen combinations of first-beat and second-beat lane masks are written over a known word, which separates the lanes from each other and one beat's mask from the other's. Junk data on no-op slots and on phase-low edges shows whether those cycles leak into the array. A write to an odd address shows whether the pairing wraps. A read and write issued together to the same address shows whether the read sees the new data. Stopping the clock in the middle of a burst shows whether state is held.

// File: rtl/sram_b2_pkg.sv
package sram_b2_pkg;
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_LO   = 2'd1,
    RD_HI   = 2'd2
  } rd_beat_e;
endpackage

// File: rtl/sram_b2_wr.sv
module sram_b2_wr #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phase_i,
  input  logic              wps_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bw_ni,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [LANES-1:0]  wlane_o
);
  logic              beat0;
  logic              pend_q;
  logic [ADDR_W-1:0] pend_a_q;

  assign beat0 = phase_i & ~wps_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      pend_a_q <= '0;
    end else begin
      pend_q <= beat0;
      if (beat0) pend_a_q <= addr_i;
    end
  end

  // second beat goes to the partner word of the aligned pair
  assign waddr_o = pend_q ? {pend_a_q[ADDR_W-1:1], ~pend_a_q[0]} : addr_i;
  assign wlane_o = (beat0 | pend_q) ? ~bw_ni : '0;
endmodule

// File: rtl/sram_b2_mem.sv
module sram_b2_mem #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES-1:0]        wlane_i,
  input  logic [LANE_W*LANES-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANE_W*LANES-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wlane_i[g]) cell_q[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = cell_q[raddr_i];
  end
endmodule

// File: rtl/sram_b2_rd.sv
module sram_b2_rd
  import sram_b2_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 18,
  parameter int RD_HALF_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phase_i,
  input  logic              rps_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvld_o
);
  localparam int LAST = RD_HALF_LAT - 1;

  logic [RD_HALF_LAT-1:0] dly_v_q;
  logic [ADDR_W-1:0]      dly_a_q [RD_HALF_LAT];
  rd_beat_e               beat_q, beat_d;
  logic [ADDR_W-1:0]      out_a_q;
  logic [DATA_W-1:0]      out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_v_q[0] <= 1'b0;
      dly_a_q[0] <= '0;
    end else begin
      dly_v_q[0] <= phase_i & ~rps_ni;
      dly_a_q[0] <= addr_i;
    end
  end

  for (genvar s = 1; s < RD_HALF_LAT; s++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dly_v_q[s] <= 1'b0;
        dly_a_q[s] <= '0;
      end else begin
        dly_v_q[s] <= dly_v_q[s-1];
        dly_a_q[s] <= dly_a_q[s-1];
      end
    end
  end

  always_comb begin
    if (dly_v_q[LAST])       beat_d = RD_LO;
    else if (beat_q == RD_LO) beat_d = RD_HI;
    else                      beat_d = RD_IDLE;
  end

  assign mem_raddr_o = dly_v_q[LAST] ? dly_a_q[LAST]
                                     : {out_a_q[ADDR_W-1:1], ~out_a_q[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q  <= RD_IDLE;
      out_a_q <= '0;
      out_q   <= '0;
    end else begin
      beat_q <= beat_d;
      if (dly_v_q[LAST]) out_a_q <= dly_a_q[LAST];
      out_q <= (beat_d != RD_IDLE) ? mem_rdata_i : '0;
    end
  end

  assign rdata_o = out_q;
  assign rvld_o  = (beat_q != RD_IDLE);
endmodule

// File: rtl/sram_b2.sv
module sram_b2 #(
  parameter int ADDR_W      = 8,
  parameter int LANE_W      = 9,
  parameter int LANES       = 2,
  parameter int RD_HALF_LAT = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    phase_i,
  input  logic                    rps_ni,
  input  logic                    wps_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANE_W*LANES-1:0] wdata_i,
  input  logic [LANES-1:0]        bw_ni,
  output logic [LANE_W*LANES-1:0] rdata_o,
  output logic                    rvld_o
);
  localparam int DATA_W = LANE_W * LANES;

  logic [ADDR_W-1:0] waddr;
  logic [LANES-1:0]  wlane;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] mem_rdata;

  sram_b2_wr #(.ADDR_W(ADDR_W), .LANES(LANES)) i_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase_i),
    .wps_ni  (wps_ni),
    .addr_i  (addr_i),
    .bw_ni   (bw_ni),
    .waddr_o (waddr),
    .wlane_o (wlane)
  );

  sram_b2_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_mem (
    .clk_i   (clk_i),
    .waddr_i (waddr),
    .wlane_i (wlane),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  sram_b2_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_HALF_LAT(RD_HALF_LAT)) i_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_i     (phase_i),
    .rps_ni      (rps_ni),
    .addr_i      (addr_i),
    .mem_raddr_o (raddr),
    .mem_rdata_i (mem_rdata),
    .rdata_o     (rdata_o),
    .rvld_o      (rvld_o)
  );
endmodule

// File: rtl/sram_b2_chk.sv
module sram_b2_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              phase_i,
  input logic              rps_ni,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvld_o
);
  logic rd_cmd;
  assign rd_cmd = phase_i & ~rps_ni;

  // R3
  first_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_cmd, 4) |-> rvld_o);

  // R3
  second_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_cmd, 5) |-> rvld_o);

  // R4
  vld_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvld_o |-> ($past(rd_cmd, 4) || $past(rd_cmd, 5)));

  // R4
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvld_o |-> (rdata_o == '0));

  // R9
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |=> !rvld_o);
endmodule

bind sram_b2 sram_b2_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .phase_i (phase_i),
  .rps_ni  (rps_ni),
  .rdata_o (rdata_o),
  .rvld_o  (rvld_o)
);

// File: tb/test_sram_b2.sv
`timescale 1ns/1ps
module test_sram_b2;
  logic        clk = 1'b0;
  logic        clk_en = 1'b1;
  logic        rst_n = 1'b0;
  logic        phase = 1'b0;
  logic        rps_n = 1'b1;
  logic        wps_n = 1'b1;
  logic [7:0]  addr = '0;
  logic [17:0] wdata = '0;
  logic [1:0]  bw_n = 2'b11;
  logic [17:0] rdata;
  logic        rvld;

  int n_chk = 0;
  int n_fail = 0;
  bit chk_on = 1'b0;
  string cur = "R3";

  always #10 if (clk_en) clk = ~clk;

  sram_b2 i_sram_b2 (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(phase), .rps_ni(rps_n), .wps_ni(wps_n),
    .addr_i(addr), .wdata_i(wdata), .bw_ni(bw_n), .rdata_o(rdata), .rvld_o(rvld)
  );

  // reference model
  logic [17:0] ref_mem [256];
  int q_due[$];
  int q_adr[$];
  int edge_n = 0;
  bit pend = 1'b0;
  int pend_a = 0;
  bit exp_v = 1'b0;
  logic [17:0] exp_d = '0;

  function automatic logic [17:0] mrg(logic [17:0] o, logic [17:0] d, logic [1:0] m);
    logic [17:0] r = o;
    if (!m[0]) r[8:0] = d[8:0];
    if (!m[1]) r[17:9] = d[17:9];
    return r;
  endfunction

  function automatic logic [17:0] pat(int a);
    return 18'(a * 311 + 18'h15a3c);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q_due.delete(); q_adr.delete();
      pend = 1'b0; exp_v = 1'b0; exp_d = '0; edge_n = 0;
    end else begin
      edge_n++;
      exp_v = 1'b0; exp_d = '0;
      if (q_due.size() > 0 && q_due[0] == edge_n) begin
        exp_v = 1'b1;
        exp_d = ref_mem[q_adr[0]];
        void'(q_due.pop_front());
        void'(q_adr.pop_front());
      end
      if (pend) ref_mem[pend_a ^ 1] = mrg(ref_mem[pend_a ^ 1], wdata, bw_n);
      pend = 1'b0;
      if (phase && !wps_n) begin
        ref_mem[int'(addr)] = mrg(ref_mem[int'(addr)], wdata, bw_n);
        pend = 1'b1; pend_a = int'(addr);
      end
      if (phase && !rps_n) begin
        q_due.push_back(edge_n + 3); q_adr.push_back(int'(addr));
        q_due.push_back(edge_n + 4); q_adr.push_back(int'(addr) ^ 1);
      end
    end
  end

  // per-edge comparison, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      n_chk++;
      if (rvld !== exp_v) begin
        n_fail++;
        $display("FAIL R4 (%s) edge %0d: rvld=%b expected %b", cur, edge_n, rvld, exp_v);
      end else if (exp_v && rdata !== exp_d) begin
        n_fail++;
        $display("FAIL %s edge %0d: rdata=%h expected %h", cur, edge_n, rdata, exp_d);
      end else if (!exp_v && rdata !== 18'h0) begin
        n_fail++;
        $display("FAIL R4 edge %0d: idle rdata=%h expected 0", edge_n, rdata);
      end
    end
  end

  task automatic drive(bit ph, bit rn, bit wn, int a, logic [17:0] d, logic [1:0] m);
    phase = ph; rps_n = rn; wps_n = wn; addr = 8'(a); wdata = d; bw_n = m;
  endtask

  task automatic half(bit ph, bit rn, bit wn, int a, logic [17:0] d, logic [1:0] m);
    @(negedge clk);
    drive(ph, rn, wn, a, d, m);
  endtask

  task automatic issue(bit rd, bit wr, int a, logic [17:0] d0, logic [1:0] m0,
                       logic [17:0] d1, logic [1:0] m1);
    half(1'b1, !rd, !wr, a, d0, m0);
    half(1'b0, 1'b1, 1'b1, a, d1, m1);
  endtask

  task automatic idle2();
    half(1'b1, 1'b1, 1'b1, 0, 18'h0, 2'b11);
    half(1'b0, 1'b1, 1'b1, 0, 18'h0, 2'b11);
  endtask

  task automatic own_chk(bit ok, string tag, logic [17:0] act, logic [17:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [17:0] hold;
    drive(1'b0, 1'b1, 1'b1, 0, 18'h0, 2'b11);
    repeat (3) begin
      @(negedge clk);
      // R9 quiet during reset
      own_chk(rvld === 1'b0 && rdata === 18'h0, "R9", {rvld, rdata[16:0]}, 18'h0);
    end
    rst_n = 1'b1;
    chk_on = 1'b1;

    // prefill every pair with full masks
    cur = "R2";
    for (int a = 0; a < 256; a += 2) issue(1'b0, 1'b1, a, pat(a), 2'b00, pat(a + 1), 2'b00);
    idle2();

    // R9 still idle after release
    own_chk(rvld === 1'b0, "R9", {17'h0, rvld}, 18'h0);

    // R3 single reads, even and odd start
    cur = "R3";
    issue(1'b1, 1'b0, 10, 18'h0, 2'b11, 18'h0, 2'b11);
    idle2(); idle2();
    issue(1'b1, 1'b0, 13, 18'h0, 2'b11, 18'h0, 2'b11);
    idle2(); idle2();

    // R11 back-to-back reads
    cur = "R11";
    issue(1'b1, 1'b0, 20, 18'h0, 2'b11, 18'h0, 2'b11);
    issue(1'b1, 1'b0, 22, 18'h0, 2'b11, 18'h0, 2'b11);
    issue(1'b1, 1'b0, 25, 18'h0, 2'b11, 18'h0, 2'b11);
    idle2(); idle2(); idle2();

    // R6 R7 every lane mask on each beat
    cur = "R6 R7";
    for (int m0 = 0; m0 < 4; m0++) begin
      for (int m1 = 0; m1 < 4; m1++) begin
        issue(1'b0, 1'b1, 40, 18'h3ffff, 2'b00, 18'h3ffff, 2'b00);
        issue(1'b0, 1'b1, 40, 18'h0a5a5 ^ 18'(m0), 2'(m0), 18'h15a5a ^ 18'(m1), 2'(m1));
        issue(1'b1, 1'b0, 40, 18'h0, 2'b11, 18'h0, 2'b11);
        idle2(); idle2();
      end
    end

    // R5 no-op slots with junk data and strobes low
    cur = "R5";
    for (int k = 0; k < 6; k++) begin
      half(1'b1, 1'b1, 1'b1, 40 + k, 18'h2dead ^ 18'(k), 2'b00);
      half(1'b0, 1'b1, 1'b1, 41 + k, 18'h1beef ^ 18'(k), 2'b00);
    end
    issue(1'b1, 1'b0, 40, 18'h0, 2'b11, 18'h0, 2'b11);
    issue(1'b1, 1'b0, 44, 18'h0, 2'b11, 18'h0, 2'b11);
    idle2(); idle2(); idle2();

    // R1 selects low on a phase-low edge are ignored
    cur = "R1";
    half(1'b1, 1'b1, 1'b1, 0, 18'h0, 2'b11);
    half(1'b0, 1'b0, 1'b0, 60, 18'h33333, 2'b00);
    idle2();
    issue(1'b1, 1'b0, 60, 18'h0, 2'b11, 18'h0, 2'b11);
    idle2(); idle2();

    // R2 pairing wraps within aligned pair
    cur = "R2";
    issue(1'b0, 1'b1, 7, 18'h11111, 2'b00, 18'h22222, 2'b00);
    issue(1'b1, 1'b0, 6, 18'h0, 2'b11, 18'h0, 2'b11);
    idle2(); idle2();

    // R8 read+write same slot, then write followed at once by read
    cur = "R8";
    issue(1'b1, 1'b1, 80, 18'h30f0f, 2'b00, 18'h0f0f0, 2'b10);
    issue(1'b0, 1'b1, 82, 18'h12345, 2'b01, 18'h2abcd, 2'b00);
    issue(1'b1, 1'b0, 83, 18'h0, 2'b11, 18'h0, 2'b11);
    idle2(); idle2();

    // R10 clock stopped mid-burst
    cur = "R10";
    issue(1'b1, 1'b0, 90, 18'h0, 2'b11, 18'h0, 2'b11);
    idle2();
    @(negedge clk);
    hold = rdata;
    own_chk(rvld === 1'b1 && rdata === ref_mem[90], "R10", rdata, ref_mem[90]);
    clk_en = 1'b0;
    #200;
    own_chk(rvld === 1'b1 && rdata === hold, "R10", rdata, hold);
    drive(1'b1, 1'b1, 1'b1, 0, 18'h0, 2'b11);
    clk_en = 1'b1;
    half(1'b0, 1'b1, 1'b1, 0, 18'h0, 2'b11);
    idle2();
    issue(1'b1, 1'b0, 80, 18'h0, 2'b11, 18'h0, 2'b11);
    idle2(); idle2();

    chk_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule